// File: doc/BRIEF.md
# Shadow Store/Recall Transfer Sequencer

This block holds two byte-wide arrays of equal depth: a working array that the host reads and writes through a plain byte port, and a shadow array that stands in for nonvolatile storage. A one-cycle store request copies the whole working array into the shadow. A one-cycle recall request copies the shadow back into the working array. The host port uses active-low chip, write and output enables. The data output is qualified by a drive-enable flag. When that flag is low, the bus counts as high impedance.

A store is done in two phases. First the entire shadow is wiped to all ones in one cycle. Then it is programmed one byte per cycle from the working array. A recall mirrors this: the working array is cleared to all zeros in one cycle, then loaded one byte per cycle from the shadow. The shadow is never modified by a recall.

Each transfer holds `busy` high for a fixed number of clock cycles, set by a parameter. During that time the host port is locked out. The parameters must be at least the array depth plus one, so that the copy always finishes before `busy` drops.

Top module: `nvshadow_xfer`

## Requirements
- R1: Once reset has been released, `busy` is low and `dout_oe` is low.
- R2: A read is taken at a clock edge that sees `ce_n`=0, `oe_n`=0 and `we_n`=1. In the next cycle, `dout_oe` is 1 and `dout` holds the byte at `addr`. A write is taken at an edge that sees `ce_n`=0 and `we_n`=0, and stores `din` at `addr`.
- R3: In the cycle after a write edge, `dout_oe` is 0 even if `oe_n` was low. This is also true after a chip-enabled edge with `oe_n` high.
- R4: In any cycle where `store_req` or `recall_req` is high, `dout_oe` is 0 in that same cycle.
- R5: A store accepted at an edge holds `busy` high for exactly STORE_CYC cycles, starting with the cycle after that edge.
- R6: While `busy` is high, and at the accepting edge itself, host reads leave `dout_oe` low and host writes do not change the working array.
- R7: A request seen while `busy` is high is dropped. `busy` rises only in the cycle after a request, and stays low after a transfer ends unless a new request comes.
- R8: A recall accepted at an edge holds `busy` high for exactly RECALL_CYC cycles, starting with the cycle after that edge.
- R9: After a store and then a recall, every address from 0 to the last one reads back the value the working array held when the store was accepted. A second recall gives the same contents, because a recall leaves the shadow unchanged.
- R10: If `store_req` and `recall_req` are high at the same idle edge, the store is performed and the recall is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| din | input | DW | Write data |
| store_req | input | 1 | One-cycle request to copy working array into shadow |
| recall_req | input | 1 | One-cycle request to copy shadow into working array |
| dout | output | DW | Read data, meaningful only when dout_oe is high |
| dout_oe | output | 1 | Output drive enable; low means high impedance |
| busy | output | 1 | Transfer in progress, host port locked |

## Verification
The hardest thing to show from the ports is that the shadow really holds the snapshot taken when the store was accepted. The shadow cannot be read directly; it only shows up through a later recall. To get at it, the stimulus does several things in order. It first fills the working array. It then stores, and during the store window it tries a write and a recall request. It then overwrites the working array with different data. Finally it recalls twice, rewriting one byte in between, and reads every address against the snapshot. The simultaneous-request case is confirmed the same way: a changed working image is stored, and a later recall must bring that image back.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RECALL = 2'd2
  } nvs_op_e;

  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_WIPE = 2'd1,
    PH_COPY = 2'd2
  } nvs_phase_e;
endpackage

// File: rtl/nvs_dwell_timer.sv
module nvs_dwell_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = load_val;
    else if (run && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvs_walker.sv
module nvs_walker
  import nvs_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          wipe,
  output logic          copy,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = '1;

  nvs_phase_e    ph_q, ph_d;
  logic [AW-1:0] idx_q, idx_d;

  always_comb begin
    ph_d  = ph_q;
    idx_d = idx_q;
    if (start) begin
      ph_d  = PH_WIPE;
      idx_d = '0;
    end else begin
      case (ph_q)
        PH_WIPE: ph_d = PH_COPY;
        PH_COPY: begin
          if (idx_q == LAST) ph_d = PH_HOLD;
          else               idx_d = idx_q + 1'b1;
        end
        default: ph_d = PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_HOLD;
      idx_q <= '0;
    end else begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
    end
  end

  assign wipe = (ph_q == PH_WIPE);
  assign copy = (ph_q == PH_COPY);
  assign idx  = idx_q;
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_rdata,
  input  logic          clear_work,
  input  logic          erase_shadow,
  input  logic          load_work,
  input  logic          prog_shadow,
  input  logic [AW-1:0] idx
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] work_q [DEPTH];
  logic [DW-1:0] shad_q [DEPTH];

  // Working array: bulk clear, per-byte load, or host write.
  always_ff @(posedge clk) begin
    if (clear_work) begin
      for (int i = 0; i < DEPTH; i++) work_q[i] <= '0;
    end else if (load_work) begin
      work_q[idx] <= shad_q[idx];
    end else if (host_we) begin
      work_q[host_addr] <= host_din;
    end
  end

  // Shadow array: bulk erase to ones, then per-byte program.
  always_ff @(posedge clk) begin
    if (erase_shadow) begin
      for (int i = 0; i < DEPTH; i++) shad_q[i] <= '1;
    end else if (prog_shadow) begin
      shad_q[idx] <= work_q[idx];
    end
  end

  assign host_rdata = work_q[host_addr];
endmodule

// File: rtl/nvshadow_xfer.sv
module nvshadow_xfer
  import nvs_pkg::*;
#(
  parameter int AW         = 11,
  parameter int DW         = 8,
  parameter int STORE_CYC  = 1250000,
  parameter int RECALL_CYC = 2500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          store_req,
  input  logic          recall_req,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          busy
);
  localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ST_LOAD = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] RC_LOAD = CW'(RECALL_CYC - 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  nvs_op_e       op_q, op_d;
  logic          req_any, start, expired;
  logic          host_ok, host_wr, host_rd;
  logic          rd_en_q, rd_en_d;
  logic [DW-1:0] dout_q, dout_d, rdata;
  logic          wipe, copy;
  logic [AW-1:0] idx;

  assign req_any = store_req | recall_req;
  assign start   = (op_q == OP_IDLE) & req_any;
  assign host_ok = (op_q == OP_IDLE) & ~req_any & ~ce_n;
  assign host_wr = host_ok & ~we_n;
  assign host_rd = host_ok & we_n & ~oe_n;

  always_comb begin
    op_d = op_q;
    if (start)                              op_d = store_req ? OP_STORE : OP_RECALL;
    else if (op_q != OP_IDLE && expired)    op_d = OP_IDLE;
  end

  always_comb begin
    rd_en_d = host_rd;
    dout_d  = host_rd ? rdata : dout_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IDLE;
      rd_en_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      op_q    <= op_d;
      rd_en_q <= rd_en_d;
      dout_q  <= dout_d;
    end
  end

  nvs_dwell_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (start),
    .load_val (store_req ? ST_LOAD : RC_LOAD),
    .run      (op_q != OP_IDLE),
    .expired  (expired)
  );

  nvs_walker #(.AW(AW)) u_walk (
    .clk   (clk),
    .rst_n (rst_ni),
    .start (start),
    .wipe  (wipe),
    .copy  (copy),
    .idx   (idx)
  );

  nvs_arrays #(.AW(AW), .DW(DW)) u_arr (
    .clk          (clk),
    .host_we      (host_wr),
    .host_addr    (addr),
    .host_din     (din),
    .host_rdata   (rdata),
    .clear_work   (wipe & (op_q == OP_RECALL)),
    .erase_shadow (wipe & (op_q == OP_STORE)),
    .load_work    (copy & (op_q == OP_RECALL)),
    .prog_shadow  (copy & (op_q == OP_STORE)),
    .idx          (idx)
  );

  assign busy    = (op_q != OP_IDLE);
  assign dout    = dout_q;
  assign dout_oe = rd_en_q & ~req_any;
endmodule

// File: rtl/nvs_xfer_chk.sv
module nvs_xfer_chk #(
  parameter int AW         = 11,
  parameter int DW         = 8,
  parameter int STORE_CYC  = 1250000,
  parameter int RECALL_CYC = 2500
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] din,
  input logic          store_req,
  input logic          recall_req,
  input logic [DW-1:0] dout,
  input logic          dout_oe,
  input logic          busy
);
  logic [31:0] len_q;
  logic        kind_st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= '0;
      kind_st_q <= 1'b0;
    end else begin
      len_q <= busy ? len_q + 1 : '0;
      if (!busy) kind_st_q <= store_req;
    end
  end

  assert_wr_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> !dout_oe);

  assert_req_undriven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |-> !dout_oe);

  assert_store_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && kind_st_q) |-> ($past(len_q) == 32'(STORE_CYC - 1)));

  assert_busy_undriven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_oe);

  assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(store_req || recall_req));

  assert_recall_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !kind_st_q) |-> ($past(len_q) == 32'(RECALL_CYC - 1)));

  always_comb begin
    if (rst_n && dout_oe) assert_oe_known_R2: assert (!$isunknown(dout));
  end
endmodule

bind nvshadow_xfer nvs_xfer_chk #(
  .AW(AW), .DW(DW), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .addr(addr), .din(din), .store_req(store_req), .recall_req(recall_req),
  .dout(dout), .dout_oe(dout_oe), .busy(busy)
);

// File: tb/sim_nvshadow_xfer.sv
module sim_nvshadow_xfer;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int SC = 40;
  localparam int RC = 30;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, ce_n, we_n, oe_n, store_req, recall_req;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dout_oe, busy;

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] snap  [DEPTH];

  typedef struct { logic [DW-1:0] d; bit z; string tag; } item_t;
  item_t expq[$];

  always #4 clk = ~clk;

  nvshadow_xfer #(.AW(AW), .DW(DW), .STORE_CYC(SC), .RECALL_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .store_req(store_req), .recall_req(recall_req),
    .dout(dout), .dout_oe(dout_oe), .busy(busy));

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares the cycle after each captured host access.
  initial begin
    forever begin
      @(posedge clk);
      if (expq.size() > 0) begin
        item_t it;
        #2;
        it = expq.pop_front();
        if (it.z) chk(!dout_oe, it.tag, dout_oe, 0);
        else      chk(dout_oe && dout == it.d, it.tag, {dout_oe, dout}, {1'b1, it.d});
      end
    end
  end

  task automatic drive(bit c, bit w, bit o, int a, int d, bit st, bit rc);
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; addr = AW'(a); din = DW'(d);
    store_req = st; recall_req = rc;
  endtask

  task automatic idle(); drive(1, 1, 1, 0, 0, 0, 0); endtask

  task automatic wr(int a, int d);
    drive(0, 0, 1, a, d, 0, 0);
    model[a] = DW'(d);
  endtask

  task automatic rd(int a, logic [DW-1:0] e, string tag);
    item_t it;
    drive(0, 1, 0, a, 0, 0, 0);
    it.d = e; it.z = 0; it.tag = tag;
    expq.push_back(it);
  endtask

  task automatic push_z(string tag);
    item_t it;
    it.d = '0; it.z = 1; it.tag = tag;
    expq.push_back(it);
  endtask

  // Issue a request and count busy cycles; optionally poke the port meanwhile.
  task automatic run_req(bit st, bit rc, int exp_len, string tag, bit poke);
    int n = 0;
    drive(0, 1, 0, 4, 0, st, rc);
    #2 chk(!dout_oe, "R4 outputs off in request cycle", dout_oe, 0);
    push_z("R6 read at accepting edge");
    @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 1; store_req = 0; recall_req = 0;
    while (busy) begin
      n++;
      if (poke && n == 3) begin
        ce_n = 0; we_n = 1; oe_n = 0; addr = '0;
        push_z("R6 read while busy");
      end else if (poke && n == 5) begin
        ce_n = 0; we_n = 0; oe_n = 1; addr = '0; din = 8'h5A;
      end else if (poke && n == 7) begin
        ce_n = 1; we_n = 1; oe_n = 1; recall_req = 1; store_req = 1;
      end else begin
        ce_n = 1; we_n = 1; oe_n = 1; store_req = 0; recall_req = 0;
      end
      @(negedge clk);
    end
    chk(n == exp_len, tag, n, exp_len);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busy, "R7 busy stays low after transfer", busy, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 0; ce_n = 1; we_n = 1; oe_n = 1; addr = '0; din = '0;
    store_req = 0; recall_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy,    "R1 busy after reset", busy, 0);
    chk(!dout_oe, "R1 dout_oe after reset", dout_oe, 0);

    // R2: fill and read back, including first and last address.
    for (int i = 0; i < DEPTH; i++) wr(i, (i * 37 + 5) & 8'hFF);
    wr(0, 8'h00);
    wr(DEPTH - 1, 8'hFF);
    for (int i = 0; i < DEPTH; i++) rd(i, model[i], "R2 read after write");

    // R3: write with oe low, and chip-enabled edge with oe high.
    rd(1, model[1], "R2 read before write");
    drive(0, 0, 0, 2, 8'hC3, 0, 0); model[2] = 8'hC3;
    push_z("R3 write with oe low");
    drive(0, 1, 1, 2, 0, 0, 0);
    push_z("R3 oe high");
    rd(2, 8'hC3, "R3 written byte");

    // Store with port poking during the window (R5, R6, R7).
    rd(3, model[3], "R2 read before request");
    for (int i = 0; i < DEPTH; i++) snap[i] = model[i];
    run_req(1, 0, SC, "R5 store busy length", 1);
    for (int i = 0; i < DEPTH; i++) rd(i, model[i], "R6 write while busy ignored");

    // Overwrite working array, then recall (R8, R9).
    for (int i = 0; i < DEPTH; i++) wr(i, ~model[i]);
    rd(0, 8'hFF, "R2 overwrite");
    run_req(0, 1, RC, "R8 recall busy length", 0);
    for (int i = 0; i < DEPTH; i++) rd(i, snap[i], "R9 recall restores snapshot");

    wr(5, 8'h77);
    run_req(0, 1, RC, "R8 second recall length", 0);
    for (int i = 0; i < DEPTH; i++) rd(i, snap[i], "R9 shadow unchanged by recall");

    // R10: both requests together run a store.
    for (int i = 0; i < DEPTH; i++) wr(i, (i * 11 + 1) & 8'hFF);
    for (int i = 0; i < DEPTH; i++) snap[i] = model[i];
    run_req(1, 1, SC, "R10 simultaneous requests run store", 0);
    for (int i = 0; i < DEPTH; i++) rd(i, snap[i], "R10 working kept after store");
    wr(DEPTH - 1, 8'h00);
    run_req(0, 1, RC, "R8 recall after R10", 0);
    for (int i = 0; i < DEPTH; i++) rd(i, snap[i], "R10 shadow holds stored image");

    idle();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule